// File: doc/BRIEF.md
# Control Endpoint Phase Tracker

This block follows the stage of each control transfer on endpoint zero of a USB device controller. It watches two strobes. One reports that a SETUP packet has landed, together with the fields decoded from its 8-byte header. The other reports that a data or handshake transfer on endpoint zero has finished, with a flag that says whether that transfer carried zero bytes. From these it keeps a two-bit phase, pulses an error output when a completion arrives in an order the protocol does not allow, and requests re-arming of SETUP reception at the end of each transfer.

A transfer with a data stage must see two completions: the data stage, which has nonzero length, and the zero-length status handshake. The two can be reported in either order. A combined waiting phase absorbs whichever comes first and then waits for the other. A SET_ADDRESS request writes the new device address as soon as the SETUP is accepted, without waiting for the status stage. A SETUP reported while the receive transfer still has bytes outstanding is treated as spurious: it is dropped and reception is re-armed. The re-armed receive accepts one SETUP packet of 8 bytes, and the buffer behind it must hold up to 64 bytes.

Top module: `ctrl_phase_tracker`

## Requirements
- R1: After the asynchronous active-low reset, phase is 0, dev_addr is 0, and err_pulse, rearm_req and addr_we are all low.
- R2: A SETUP accepted in phase 0 (wait-setup), with rx_remaining equal to 0, moves to phase 3 (wait-data-and-ack) when the 16-bit length field is nonzero and to phase 1 (wait-ack) when it is zero. The length field is made of header bytes 6 (low) and 7 (high).
- R3: In phase 3, a zero-length completion moves to phase 2 (wait-data) and a nonzero-length completion moves to phase 1.
- R4: In phase 1, a zero-length completion returns to phase 0 and pulses rearm_req. A nonzero-length completion pulses err_pulse and leaves the phase unchanged.
- R5: In phase 2, a nonzero-length completion returns to phase 0 and pulses rearm_req. A zero-length completion pulses err_pulse and leaves the phase unchanged.
- R6: A completion in phase 0 pulses err_pulse and leaves the phase at 0.
- R7: A SETUP that arrives while rx_remaining is nonzero changes neither the phase nor dev_addr, does not pulse addr_we, and pulses rearm_req.
- R8: An accepted SETUP with request type 0x00 (header byte 0) and request code 5 (header byte 1) loads dev_addr from the low ADDR_W bits of the value field (header byte 2 upward) and pulses addr_we. Any other request leaves dev_addr unchanged.
- R9: An accepted SETUP in phase 1, 2 or 3 leaves the phase unchanged. R8 still applies to it.
- R10: bus_reset overrides every other input. It sets phase 0 and dev_addr 0 and pulses rearm_req, with no err_pulse and no addr_we.
- R11: When a SETUP and a completion are reported in the same cycle, the completion is ignored.
- R12: Every output reflects the inputs of the previous rising edge. err_pulse, rearm_req and addr_we each last one cycle per event, and err_pulse and rearm_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | USB bus reset seen, synchronous |
| setup_valid | input | 1 | SETUP packet received strobe |
| setup_type | input | 8 | Header byte 0, request type |
| setup_code | input | 8 | Header byte 1, request code |
| setup_value | input | ADDR_W | Low bits of the header value field |
| setup_length | input | 16 | Header length field, bytes 6 and 7 |
| rx_remaining | input | CNT_W | Bytes still outstanding on the current receive |
| xfer_done | input | 1 | Endpoint-zero transfer complete strobe |
| xfer_zero_len | input | 1 | The finished transfer had zero length |
| phase | output | 2 | Current control phase, 0 to 3 |
| err_pulse | output | 1 | One-cycle illegal-ordering flag |
| rearm_req | output | 1 | One-cycle request to re-arm SETUP reception |
| addr_we | output | 1 | One-cycle strobe: dev_addr was just loaded |
| dev_addr | output | ADDR_W | Current device address |

## Verification
Every result of this block is due exactly one rising edge after the edge that sampled the stimulus: the phase, the error, re-arm and address-write pulses, and the new address. The bench changes the inputs on the falling edge, steps its own model at the rising edge, and compares all five outputs 1 ns after that edge. A pulse is therefore checked both in the cycle it is due and in the cycle after, where it must be low again. The spurious and overridden cases are checked at the same point, by confirming that the phase and address stayed where they were.

// File: rtl/ctrl_phase_pkg.sv
package ctrl_phase_pkg;

   typedef enum logic [1:0] {
      PH_WAIT_SETUP    = 2'd0,
      PH_WAIT_ACK      = 2'd1,
      PH_WAIT_DATA     = 2'd2,
      PH_WAIT_DATA_ACK = 2'd3
   } ctl_phase_e;

   localparam logic [7:0] REQTYPE_STD_DEV = 8'h00;
   localparam logic [7:0] REQCODE_SET_ADR = 8'd5;

endpackage

// File: rtl/cpt_hdr_decode.sv
module cpt_hdr_decode #(
   parameter int ADDR_W = 7,
   parameter int LEN_W  = 16
) (
   input  logic [7:0]        req_type,
   input  logic [7:0]        req_code,
   input  logic [ADDR_W-1:0] req_value,
   input  logic [LEN_W-1:0]  req_length,
   output logic              has_data,
   output logic              is_set_addr,
   output logic [ADDR_W-1:0] new_addr
);
   import ctrl_phase_pkg::*;

   localparam int LEN_BYTES = (LEN_W + 7) / 8;

   logic [LEN_BYTES-1:0] byte_nz;

   // The length field is scanned byte by byte: the stage has data if any byte is nonzero.
   for (genvar b = 0; b < LEN_BYTES; b++) begin : g_len_byte
      localparam int HI = ((b + 1) * 8 > LEN_W) ? LEN_W - 1 : (b * 8 + 7);
      assign byte_nz[b] = |req_length[HI:b*8];
   end

   always_comb begin
      has_data    = |byte_nz;
      is_set_addr = (req_type == REQTYPE_STD_DEV) && (req_code == REQCODE_SET_ADR);
      new_addr    = req_value;
   end

endmodule

// File: rtl/cpt_phase_fsm.sv
module cpt_phase_fsm (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_reset,
   input  logic       setup_ok,
   input  logic       setup_spur,
   input  logic       has_data,
   input  logic       done,
   input  logic       done_zero,
   output logic [1:0] phase,
   output logic       err_pulse,
   output logic       rearm_req
);
   import ctrl_phase_pkg::*;

   ctl_phase_e cur_q;

   assign phase = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= PH_WAIT_SETUP;
         err_pulse <= 1'b0;
         rearm_req <= 1'b0;
      end else begin
         err_pulse <= 1'b0;
         rearm_req <= 1'b0;
         if (bus_reset) begin
            cur_q     <= PH_WAIT_SETUP;
            rearm_req <= 1'b1;
         end else if (setup_spur) begin
            rearm_req <= 1'b1;
         end else if (setup_ok) begin
            if (cur_q == PH_WAIT_SETUP)
               cur_q <= has_data ? PH_WAIT_DATA_ACK : PH_WAIT_ACK;
         end else if (done) begin
            unique case (cur_q)
               PH_WAIT_SETUP: err_pulse <= 1'b1;
               PH_WAIT_DATA_ACK: cur_q <= done_zero ? PH_WAIT_DATA : PH_WAIT_ACK;
               PH_WAIT_ACK: begin
                  if (done_zero) begin
                     cur_q     <= PH_WAIT_SETUP;
                     rearm_req <= 1'b1;
                  end else begin
                     err_pulse <= 1'b1;
                  end
               end
               PH_WAIT_DATA: begin
                  if (!done_zero) begin
                     cur_q     <= PH_WAIT_SETUP;
                     rearm_req <= 1'b1;
                  end else begin
                     err_pulse <= 1'b1;
                  end
               end
               default: cur_q <= PH_WAIT_SETUP;
            endcase
         end
      end
   end

endmodule

// File: rtl/cpt_addr_reg.sv
module cpt_addr_reg #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              addr_we
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_addr <= '0;
         addr_we  <= 1'b0;
      end else begin
         addr_we <= 1'b0;
         if (bus_reset) begin
            dev_addr <= '0;
         end else if (load) begin
            dev_addr <= load_val;
            addr_we  <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ctrl_phase_tracker.sv
module ctrl_phase_tracker #(
   parameter int ADDR_W     = 7,
   parameter int CNT_W      = 7,
   parameter int SETUP_AREA = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset,
   input  logic              setup_valid,
   input  logic [7:0]        setup_type,
   input  logic [7:0]        setup_code,
   input  logic [ADDR_W-1:0] setup_value,
   input  logic [15:0]       setup_length,
   input  logic [CNT_W-1:0]  rx_remaining,
   input  logic              xfer_done,
   input  logic              xfer_zero_len,
   output logic [1:0]        phase,
   output logic              err_pulse,
   output logic              rearm_req,
   output logic              addr_we,
   output logic [ADDR_W-1:0] dev_addr
);

   localparam int LEN_W = 16;

   initial begin
      if (ADDR_W < 1 || ADDR_W > 16)
         $error("ctrl_phase_tracker: ADDR_W must be 1..16");
      if ((1 << CNT_W) <= SETUP_AREA)
         $error("ctrl_phase_tracker: CNT_W too narrow for the setup receive area");
   end

   logic              rx_idle;
   logic              setup_ok;
   logic              setup_spur;
   logic              has_data;
   logic              is_set_addr;
   logic [ADDR_W-1:0] new_addr;

   assign rx_idle    = (rx_remaining == '0);
   assign setup_ok   = setup_valid && rx_idle;
   assign setup_spur = setup_valid && !rx_idle;

   cpt_hdr_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
      .req_type    (setup_type),
      .req_code    (setup_code),
      .req_value   (setup_value),
      .req_length  (setup_length),
      .has_data    (has_data),
      .is_set_addr (is_set_addr),
      .new_addr    (new_addr)
   );

   cpt_phase_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_reset  (bus_reset),
      .setup_ok   (setup_ok),
      .setup_spur (setup_spur),
      .has_data   (has_data),
      .done       (xfer_done),
      .done_zero  (xfer_zero_len),
      .phase      (phase),
      .err_pulse  (err_pulse),
      .rearm_req  (rearm_req)
   );

   cpt_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_reset (bus_reset),
      .load      (setup_ok && is_set_addr),
      .load_val  (new_addr),
      .dev_addr  (dev_addr),
      .addr_we   (addr_we)
   );

endmodule

// File: rtl/ctrl_phase_tracker_chk.sv
module ctrl_phase_tracker_chk #(
   parameter int ADDR_W = 7,
   parameter int CNT_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_reset,
   input logic              setup_valid,
   input logic [CNT_W-1:0]  rx_remaining,
   input logic              xfer_done,
   input logic              xfer_zero_len,
   input logic [1:0]        phase,
   input logic              err_pulse,
   input logic              rearm_req,
   input logic              addr_we,
   input logic [ADDR_W-1:0] dev_addr
);

   logic seen_edge;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_edge <= 1'b0;
      else        seen_edge <= 1'b1;
   end

   p_bus_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> (phase == 2'd0) && (dev_addr == '0) && rearm_req && !err_pulse && !addr_we);

   p_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_edge && !bus_reset && setup_valid && rx_remaining != '0)
      |=> rearm_req && !addr_we && $stable(phase) && $stable(dev_addr));

   p_setup_leaves_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_reset && setup_valid && rx_remaining == '0 && phase == 2'd0)
      |=> (phase == 2'd1 || phase == 2'd3));

   p_idle_done_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_reset && !setup_valid && xfer_done && phase == 2'd0) |=> err_pulse && phase == 2'd0);

   p_ack_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_reset && !setup_valid && xfer_done && xfer_zero_len && phase == 2'd1)
      |=> phase == 2'd0 && rearm_req);

   p_data_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_reset && !setup_valid && xfer_done && !xfer_zero_len && phase == 2'd2)
      |=> phase == 2'd0 && rearm_req);

   p_err_holds_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_edge && err_pulse) |-> $stable(phase));

   p_pulse_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_pulse, rearm_req}));

   p_setup_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_reset && setup_valid && rx_remaining == '0 && phase != 2'd0) |=> $stable(phase) && !err_pulse);

endmodule

bind ctrl_phase_tracker ctrl_phase_tracker_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_reset     (bus_reset),
   .setup_valid   (setup_valid),
   .rx_remaining  (rx_remaining),
   .xfer_done     (xfer_done),
   .xfer_zero_len (xfer_zero_len),
   .phase         (phase),
   .err_pulse     (err_pulse),
   .rearm_req     (rearm_req),
   .addr_we       (addr_we),
   .dev_addr      (dev_addr)
);

// File: tb/tb_ctrl_phase_tracker.sv
`timescale 1ns/1ps
module tb_ctrl_phase_tracker;

   localparam int ADDR_W = 7;
   localparam int CNT_W  = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_reset = 1'b0;
   logic              setup_valid = 1'b0;
   logic [7:0]        setup_type = '0;
   logic [7:0]        setup_code = '0;
   logic [ADDR_W-1:0] setup_value = '0;
   logic [15:0]       setup_length = '0;
   logic [CNT_W-1:0]  rx_remaining = '0;
   logic              xfer_done = 1'b0;
   logic              xfer_zero_len = 1'b0;
   logic [1:0]        phase;
   logic              err_pulse;
   logic              rearm_req;
   logic              addr_we;
   logic [ADDR_W-1:0] dev_addr;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // model state
   logic [1:0]        m_phase = 2'd0;
   logic [ADDR_W-1:0] m_addr = '0;
   logic              m_err = 1'b0;
   logic              m_rearm = 1'b0;
   logic              m_we = 1'b0;
   string             m_tag = "R1";

   always #2 clk = ~clk;

   ctrl_phase_tracker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .setup_valid(setup_valid),
      .setup_type(setup_type), .setup_code(setup_code), .setup_value(setup_value),
      .setup_length(setup_length), .rx_remaining(rx_remaining), .xfer_done(xfer_done),
      .xfer_zero_len(xfer_zero_len), .phase(phase), .err_pulse(err_pulse),
      .rearm_req(rearm_req), .addr_we(addr_we), .dev_addr(dev_addr)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // expected behaviour from the requirements, one step per rising edge
   task automatic model_step();
      m_err = 1'b0; m_rearm = 1'b0; m_we = 1'b0;
      if (bus_reset) begin
         m_phase = 2'd0; m_addr = '0; m_rearm = 1'b1; m_tag = "R10";
      end else if (setup_valid && rx_remaining != '0) begin
         m_rearm = 1'b1; m_tag = "R7";
      end else if (setup_valid) begin
         m_tag = (m_phase == 2'd0) ? "R2" : (xfer_done ? "R11" : "R9");
         if (m_phase == 2'd0) m_phase = (setup_length != 16'd0) ? 2'd3 : 2'd1;
         if (setup_type == 8'h00 && setup_code == 8'd5) begin
            m_addr = setup_value; m_we = 1'b1; m_tag = "R8";
         end
      end else if (xfer_done) begin
         case (m_phase)
            2'd0: begin m_err = 1'b1; m_tag = "R6"; end
            2'd3: begin m_phase = xfer_zero_len ? 2'd2 : 2'd1; m_tag = "R3"; end
            2'd1: begin
               m_tag = "R4";
               if (xfer_zero_len) begin m_phase = 2'd0; m_rearm = 1'b1; end
               else m_err = 1'b1;
            end
            default: begin
               m_tag = "R5";
               if (!xfer_zero_len) begin m_phase = 2'd0; m_rearm = 1'b1; end
               else m_err = 1'b1;
            end
         endcase
      end else begin
         m_tag = "R12";
      end
   endtask

   task automatic compare_all();
      chk(m_tag, "phase", phase, m_phase);
      chk(m_tag, "dev_addr", dev_addr, m_addr);
      chk(m_tag, "err_pulse", err_pulse, m_err);
      chk(m_tag, "rearm_req", rearm_req, m_rearm);
      chk(m_tag, "addr_we", addr_we, m_we);
   endtask

   // apply inputs at the falling edge, check 1 ns after the next rising edge
   task automatic cyc(input bit br, input bit sv, input logic [7:0] ty, input logic [7:0] cd,
                      input logic [ADDR_W-1:0] va, input logic [15:0] ln,
                      input logic [CNT_W-1:0] rem, input bit dn, input bit zl);
      @(negedge clk);
      bus_reset = br; setup_valid = sv; setup_type = ty; setup_code = cd;
      setup_value = va; setup_length = ln; rx_remaining = rem;
      xfer_done = dn; xfer_zero_len = zl;
      @(posedge clk);
      model_step();
      #1;
      compare_all();
   endtask

   task automatic idle();
      cyc(0, 0, 8'h00, 8'h00, '0, 16'd0, '0, 0, 0);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      #3;
      // R1: reset values
      m_tag = "R1";
      compare_all();
      @(negedge clk); rst_n = 1'b1;
      m_tag = "R1";
      #1 compare_all();

      // R2 / R3 / R4: data stage first, then handshake
      cyc(0, 1, 8'h80, 8'd6, '0, 16'h0100, '0, 0, 0);   // length byte 7 only -> phase 3
      cyc(0, 0, 0, 0, '0, 0, '0, 1, 0);                  // R3 data -> phase 1
      cyc(0, 0, 0, 0, '0, 0, '0, 1, 1);                  // R4 ack -> 0 + rearm
      idle();                                            // R12 pulses end
      // R3 / R5: handshake first, then data
      cyc(0, 1, 8'hC0, 8'd1, '0, 16'h0001, '0, 0, 0);
      cyc(0, 0, 0, 0, '0, 0, '0, 1, 1);                  // -> phase 2
      cyc(0, 0, 0, 0, '0, 0, '0, 1, 1);                  // R5 error, held
      cyc(0, 0, 0, 0, '0, 0, '0, 1, 0);                  // R5 close
      // R6: completion in wait-setup
      cyc(0, 0, 0, 0, '0, 0, '0, 1, 0);
      // R8 SET_ADDRESS, then R4 error on nonzero completion
      cyc(0, 1, 8'h00, 8'd5, 7'h2A, 16'd0, '0, 0, 0);
      cyc(0, 0, 0, 0, '0, 0, '0, 1, 0);
      // R9 setup in non-idle phase, R11 simultaneous completion
      cyc(0, 1, 8'h00, 8'd9, 7'h11, 16'd4, '0, 1, 1);
      cyc(0, 0, 0, 0, '0, 0, '0, 1, 1);
      // R7 spurious SET_ADDRESS
      cyc(0, 1, 8'h00, 8'd5, 7'h55, 16'd0, 7'd8, 0, 0);
      // R10 bus reset overrides setup and completion
      cyc(1, 1, 8'h00, 8'd5, 7'h33, 16'd2, '0, 1, 0);
      idle();

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         bit br = ($urandom_range(0, 59) == 0);
         bit sv = ($urandom_range(0, 3) == 0);
         logic [7:0] ty = ($urandom_range(0, 1) != 0) ? 8'h00 : 8'($urandom);
         logic [7:0] cd = ($urandom_range(0, 1) != 0) ? 8'd5 : 8'($urandom_range(0, 12));
         logic [15:0] ln = ($urandom_range(0, 1) != 0) ? 16'd0 : 16'($urandom);
         logic [CNT_W-1:0] rem = ($urandom_range(0, 4) == 0) ? CNT_W'($urandom_range(1, 64)) : '0;
         bit dn = ($urandom_range(0, 1) != 0);
         bit zl = ($urandom_range(0, 1) != 0);
         cyc(br, sv, ty, cd, ADDR_W'($urandom), ln, rem, dn, zl);
      end
      idle();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule